// File: doc/BRIEF.md
# CRC-Only Source Scan DMA Channel

This block is one memory-read channel whose only product is a checksum. Once started, it walks a byte buffer in memory from a start address and pushes every byte it fetches through a programmable CRC shift register. Nothing is stored anywhere while the scan runs. When the scan finishes, either because the programmed byte count is used up or because a fetched byte equals an optional stop byte, the channel issues a single write that places the CRC at a programmed destination address. If the scan is cut short by a software abort or by a read bus error, the channel drops the result and writes nothing. Only the source count and the stop byte decide when the scan ends. The destination size only decides how many CRC bytes the final write carries.

The CRC register is `cfg_len + 1` bits wide, so it holds at most 16 bits. It is seeded from `cfg_seed`. The bits set in `cfg_poly` act as the feedback taps. Each fetched byte is shifted in least significant bit first, one bit per clock. Before a scan can be accepted, three things must agree: the append enable, the CRC enable, and a channel selector that matches the `CHAN_ID` parameter. The configuration is captured when the start pulse is accepted.

The controller has five states. ST_IDLE waits for an accepted start. ST_READ holds a read request until a response arrives. ST_SHIFT spends eight cycles feeding the fetched byte into the CRC. ST_WRITE holds the final write request until it is acknowledged. ST_FIN is the single cycle that raises `done`.

The transitions are:
- ST_IDLE to ST_READ on an accepted start.
- ST_READ to ST_SHIFT on a clean response.
- ST_READ to ST_IDLE on abort or read error.
- ST_SHIFT to ST_READ after a byte when more bytes remain.
- ST_SHIFT to ST_WRITE when the scan ends.
- ST_SHIFT to ST_FIN when the scan ends and the destination size is zero.
- ST_SHIFT to ST_IDLE on abort.
- ST_WRITE to ST_FIN on write acknowledge.
- ST_FIN to ST_IDLE always.

Top module: `dma_crc_append`

## Requirements
- R1: A start pulse is accepted only when all of the following hold: `cfg_append_en` is 1, `cfg_crc_en` is 1, `cfg_chan` equals `CHAN_ID`, and `cfg_src_size` is nonzero. If any of these fails, the block stays idle and issues no read.
- R2: An accepted scan reads bytes one at a time at `cfg_src_addr`, `cfg_src_addr+1`, and so on. It holds `rd_req` and `rd_addr` steady until `rd_valid`. It never requests a read and a write in the same cycle, and it makes no write before the last byte has been shifted.
- R3: The CRC is `cfg_len+1` bits wide and starts at `cfg_seed` masked to that width. For each data bit b, taken LSB first, the update is: fb = crc[0] xor b; crc = crc >> 1; if fb is 1, crc is XORed with `cfg_poly`; the result is then masked to the width.
- R4: Without a stop byte, exactly `cfg_src_size` bytes are read, whatever value `cfg_dst_size` has.
- R5: With `cfg_pat_en` set, the first byte equal to `cfg_pat` is included in the CRC and ends the scan. No further reads are made.
- R6: The final write goes to `cfg_dst_addr`. With n = min(`cfg_dst_size`, 4), bits 0 to n-1 of `wr_be` are set and the other bits are clear. Byte i of `wr_data` carries byte i of the CRC for i < n and is zero otherwise, so bits 31:16 are always zero.
- R7: The CRC width set by `cfg_len` never changes the number of enabled bytes in the final write.
- R8: With `cfg_dst_size` equal to 0, a scan that ends normally makes no write but still raises `done`.
- R9: `abort_req` while reading or shifting ends the scan. No write follows, `aborted` is set, and `done` is not raised.
- R10: A read response with `rd_err` set ends the scan in the same way as R9.
- R11: `done` is high for exactly one cycle, the cycle after the one in which `wr_ack` accepts the write. `aborted` stays set until the next accepted start clears it. After reset, `busy`, `done` and `aborted` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_append_en | input | 1 | Append mode enable |
| cfg_crc_en | input | 1 | CRC calculation enable |
| cfg_chan | input | 3 | Channel the CRC is attached to |
| cfg_len | input | 4 | CRC width minus one |
| cfg_poly | input | 16 | Feedback tap mask |
| cfg_seed | input | 16 | Initial CRC value |
| cfg_src_addr | input | 16 | First source byte address |
| cfg_src_size | input | 16 | Source byte count |
| cfg_dst_addr | input | 16 | Address of the CRC write |
| cfg_dst_size | input | 16 | Destination size in bytes |
| cfg_pat_en | input | 1 | Stop-byte match enable |
| cfg_pat | input | 8 | Stop byte value |
| start | input | 1 | Start pulse |
| abort_req | input | 1 | Software abort |
| rd_req | output | 1 | Read request |
| rd_addr | output | 16 | Read byte address |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 8 | Read data byte |
| rd_err | input | 1 | Read bus error, qualified by rd_valid |
| wr_req | output | 1 | Write request |
| wr_addr | output | 16 | Write address |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Write byte enables |
| wr_ack | input | 1 | Write accepted |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | Last scan ended abnormally |

## Verification
The hardest case to reach from the ports is an abort or read error that lands in the middle of a scan: after some bytes have already shifted into the CRC, but before the byte count runs out. The bench handles the abort case by raising `abort_req` a fixed number of cycles after the start, which places it inside a byte's eight-cycle shift. It handles the error case with a memory model that flags an error on one chosen address. In both cases it confirms that no write ever reaches the memory model and that `done` never rises. It then runs a clean scan afterwards to show that the `aborted` flag clears.

// File: rtl/crc_dma_pkg.sv
package crc_dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_SHIFT,
        ST_WRITE,
        ST_FIN
    } scan_state_t;
endpackage

// File: rtl/crc_lfsr.sv
module crc_lfsr #(
    parameter int LEN_W = 4,
    localparam int CRC_W = 1 << LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic [CRC_W-1:0] seed,
    input  logic [CRC_W-1:0] poly,
    input  logic             shift,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic [CRC_W:0]   wide_mask;
    logic [CRC_W-1:0] mask_q, poly_q, nxt;

    assign wide_mask = ((CRC_W+1)'(1) << ({1'b0, len} + (LEN_W+1)'(1))) - (CRC_W+1)'(1);

    always_comb begin
        nxt = crc >> 1;
        if (crc[0] ^ din) begin
            nxt = nxt ^ poly_q;
        end
        nxt = nxt & mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc    <= '0;
            mask_q <= '0;
            poly_q <= '0;
        end else if (load) begin
            crc    <= seed & wide_mask[CRC_W-1:0];
            mask_q <= wide_mask[CRC_W-1:0];
            poly_q <= poly;
        end else if (shift) begin
            crc <= nxt;
        end
    end

    // R3: register never holds bits above the programmed width
    a_r3_within_width: assert property (@(posedge clk) disable iff (!rst_n)
        (crc & ~mask_q) == '0);
endmodule

// File: rtl/src_counter.sv
module src_counter #(
    parameter int AW = 16,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] size,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [SW-1:0] remain
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr   <= '0;
            remain <= '0;
        end else if (load) begin
            addr   <= base;
            remain <= size;
        end else if (step) begin
            addr   <= addr + AW'(1);
            remain <= remain - SW'(1);
        end
    end

    // R4: count never steps below zero
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |-> remain != '0);
endmodule

// File: rtl/crc_pack.sv
module crc_pack #(
    parameter int CRC_W = 16,
    parameter int SW    = 16,
    parameter int WB    = 4
) (
    input  logic [CRC_W-1:0]  crc,
    input  logic [SW-1:0]     dst_size,
    output logic [WB*8-1:0]   data,
    output logic [WB-1:0]     be,
    output logic              none
);
    logic [WB*8-1:0] crc_ext;

    assign crc_ext = (WB*8)'(crc);
    assign none    = (dst_size == '0);

    for (genvar i = 0; i < WB; i++) begin : g_lane
        assign be[i]          = (dst_size > SW'(i));
        assign data[8*i +: 8] = be[i] ? crc_ext[8*i +: 8] : 8'h00;
    end

    // R6: enabled lanes are always a contiguous low group
    always_comb begin
        a_r6_be_contiguous: assert ((be & (be + WB'(1))) == '0);
    end
endmodule

// File: rtl/dma_crc_append.sv
module dma_crc_append
    import crc_dma_pkg::*;
#(
    parameter int          AW      = 16,
    parameter int          SW      = 16,
    parameter int          LEN_W   = 4,
    parameter int          WB      = 4,
    parameter logic [2:0]  CHAN_ID = 3'd0,
    localparam int         CRC_W   = 1 << LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_append_en,
    input  logic             cfg_crc_en,
    input  logic [2:0]       cfg_chan,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [CRC_W-1:0] cfg_poly,
    input  logic [CRC_W-1:0] cfg_seed,
    input  logic [AW-1:0]    cfg_src_addr,
    input  logic [SW-1:0]    cfg_src_size,
    input  logic [AW-1:0]    cfg_dst_addr,
    input  logic [SW-1:0]    cfg_dst_size,
    input  logic             cfg_pat_en,
    input  logic [7:0]       cfg_pat,
    input  logic             start,
    input  logic             abort_req,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    input  logic             rd_valid,
    input  logic [7:0]       rd_data,
    input  logic             rd_err,
    output logic             wr_req,
    output logic [AW-1:0]    wr_addr,
    output logic [WB*8-1:0]  wr_data,
    output logic [WB-1:0]    wr_be,
    input  logic             wr_ack,
    output logic             busy,
    output logic             done,
    output logic             aborted
);
    scan_state_t state, state_nx;

    logic [AW-1:0]    dst_addr_q;
    logic [SW-1:0]    dst_size_q;
    logic             pat_en_q;
    logic [7:0]       pat_q;
    logic [7:0]       byte_q;
    logic [2:0]       bit_q;
    logic             match_q;
    logic             aborted_q;
    logic [SW-1:0]    remain;
    logic [CRC_W-1:0] crc;
    logic             dst_none;

    logic cfg_ok, accept, rd_take, bit_step, scan_end, kill;

    assign cfg_ok   = cfg_append_en && cfg_crc_en && (cfg_chan == CHAN_ID)
                      && (cfg_src_size != '0);
    assign accept   = (state == ST_IDLE) && start && cfg_ok;
    assign rd_take  = (state == ST_READ) && !abort_req && rd_valid && !rd_err;
    assign bit_step = (state == ST_SHIFT) && !abort_req;
    assign scan_end = match_q || (remain == '0);
    assign kill     = ((state == ST_READ) && (abort_req || (rd_valid && rd_err)))
                      || ((state == ST_SHIFT) && abort_req);

    src_counter #(.AW(AW), .SW(SW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(accept), .base(cfg_src_addr),
        .size(cfg_src_size), .step(rd_take), .addr(rd_addr), .remain(remain)
    );

    crc_lfsr #(.LEN_W(LEN_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(accept), .len(cfg_len),
        .seed(cfg_seed), .poly(cfg_poly), .shift(bit_step),
        .din(byte_q[bit_q]), .crc(crc)
    );

    crc_pack #(.CRC_W(CRC_W), .SW(SW), .WB(WB)) u_pack (
        .crc(crc), .dst_size(dst_size_q), .data(wr_data), .be(wr_be),
        .none(dst_none)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_READ;
            ST_READ: begin
                if (abort_req)     state_nx = ST_IDLE;
                else if (rd_valid) state_nx = rd_err ? ST_IDLE : ST_SHIFT;
            end
            ST_SHIFT: begin
                if (abort_req) begin
                    state_nx = ST_IDLE;
                end else if (bit_q == 3'd7) begin
                    if (!scan_end)     state_nx = ST_READ;
                    else if (dst_none) state_nx = ST_FIN;
                    else               state_nx = ST_WRITE;
                end
            end
            ST_WRITE: if (wr_ack) state_nx = ST_FIN;
            ST_FIN:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_addr_q <= '0;
            dst_size_q <= '0;
            pat_en_q   <= 1'b0;
            pat_q      <= '0;
            byte_q     <= '0;
            bit_q      <= '0;
            match_q    <= 1'b0;
            aborted_q  <= 1'b0;
        end else begin
            if (accept) begin
                dst_addr_q <= cfg_dst_addr;
                dst_size_q <= cfg_dst_size;
                pat_en_q   <= cfg_pat_en;
                pat_q      <= cfg_pat;
                aborted_q  <= 1'b0;
            end
            if (kill) begin
                aborted_q <= 1'b1;
            end
            if (rd_take) begin
                byte_q  <= rd_data;
                bit_q   <= '0;
                match_q <= pat_en_q && (rd_data == pat_q);
            end else if (bit_step) begin
                bit_q <= bit_q + 3'd1;
            end
        end
    end

    // outputs
    always_comb begin
        rd_req  = (state == ST_READ);
        wr_req  = (state == ST_WRITE);
        wr_addr = dst_addr_q;
        busy    = (state != ST_IDLE);
        done    = (state == ST_FIN);
        aborted = aborted_q;
    end

    // R1: a start with zero source size is not taken
    a_r1_zero_size_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && cfg_src_size == '0) |=> !busy);
    // R2: read request and address held until response
    a_r2_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid && !abort_req) |=> (rd_req && $stable(rd_addr)));
    // R2: reads and the write never overlap
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
    // R6: upper write bits stay clear
    a_r6_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_data >> CRC_W) == '0);
    // R9: abort during scan leaves no write and returns idle
    a_r9_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_req && abort_req) |=> (!wr_req && !busy));
    // R10: read error ends the scan as aborted
    a_r10_err_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid && rd_err) |=> (aborted && !busy));
    // R11: done follows the accepted write and lasts one cycle
    a_r11_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> done);
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sim_dma_crc_append.sv
module sim_dma_crc_append;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_append_en = 1'b1, cfg_crc_en = 1'b1;
    logic [2:0]  cfg_chan = 3'd0;
    logic [3:0]  cfg_len = 4'd15;
    logic [15:0] cfg_poly = 16'hA001, cfg_seed = 16'hFFFF;
    logic [15:0] cfg_src_addr = '0, cfg_src_size = '0;
    logic [15:0] cfg_dst_addr = 16'h0200, cfg_dst_size = 16'd4;
    logic        cfg_pat_en = 1'b0;
    logic [7:0]  cfg_pat = '0;
    logic        start = 1'b0, abort_req = 1'b0;
    logic        rd_req, rd_valid = 1'b0, rd_err = 1'b0;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic        wr_req, wr_ack = 1'b0;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic        busy, done, aborted;

    logic [7:0]  mem [0:255];
    int          checks = 0, errors = 0;
    int          rd_cnt = 0, wr_cnt = 0, done_cnt = 0, cycles = 0;
    logic [15:0] cap_addr;
    logic [31:0] cap_data;
    logic [3:0]  cap_be;
    logic        err_en = 1'b0;
    logic [15:0] err_addr = '0;

    always #2.5 clk = ~clk;

    dma_crc_append u0 (
        .clk(clk), .rst_n(rst_n), .cfg_append_en(cfg_append_en), .cfg_crc_en(cfg_crc_en),
        .cfg_chan(cfg_chan), .cfg_len(cfg_len), .cfg_poly(cfg_poly), .cfg_seed(cfg_seed),
        .cfg_src_addr(cfg_src_addr), .cfg_src_size(cfg_src_size), .cfg_dst_addr(cfg_dst_addr),
        .cfg_dst_size(cfg_dst_size), .cfg_pat_en(cfg_pat_en), .cfg_pat(cfg_pat),
        .start(start), .abort_req(abort_req), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wr_ack(wr_ack),
        .busy(busy), .done(done), .aborted(aborted)
    );

    // memory model, driven away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rd_req && !rd_valid) begin
            rd_valid = 1'b1;
            rd_data  = mem[rd_addr[7:0]];
            rd_err   = err_en && (rd_addr == err_addr);
            rd_cnt++;
        end else begin
            rd_valid = 1'b0;
            rd_err   = 1'b0;
        end
        if (wr_req && !wr_ack) begin
            wr_ack   = 1'b1;
            cap_addr = wr_addr;
            cap_data = wr_data;
            cap_be   = wr_be;
            wr_cnt++;
        end else begin
            wr_ack = 1'b0;
        end
        if (done) done_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_crc(input logic [15:0] seed, input logic [15:0] poly,
                                              input int len, input int base, input int n);
        logic [16:0] m = (17'd1 << (len + 1)) - 17'd1;
        logic [15:0] c = seed & m[15:0];
        for (int k = 0; k < n; k++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ mem[(base + k) & 255][b];
                c = c >> 1;
                if (fb) c = c ^ poly;
                c = c & m[15:0];
            end
        end
        return c;
    endfunction

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 3000 && busy; t++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_case(input string req, input int base, input int size, input int dsz,
                            input int len, input logic [15:0] poly, input logic [15:0] seed,
                            input logic pen, input logic [7:0] pat, input int exp_n);
        int r0 = rd_cnt, w0 = wr_cnt, d0 = done_cnt, nb;
        logic [15:0] c;
        logic [31:0] ed;
        cfg_src_addr = 16'(base); cfg_src_size = 16'(size); cfg_dst_size = 16'(dsz);
        cfg_len = 4'(len); cfg_poly = poly; cfg_seed = seed; cfg_pat_en = pen; cfg_pat = pat;
        pulse_start();
        chk({req, " busy after start"}, 32'(busy), 1);
        wait_idle();
        c  = model_crc(seed, poly, len, base, exp_n);
        nb = (dsz > 4) ? 4 : dsz;
        ed = '0;
        for (int i = 0; i < nb; i++) ed[8*i +: 8] = 8'(32'(c) >> (8*i));
        chk({req, " read count"}, 32'(rd_cnt - r0), 32'(exp_n));
        chk({req, " done pulses"}, 32'(done_cnt - d0), 1);
        chk({req, " aborted clear"}, 32'(aborted), 0);
        if (dsz == 0) begin
            chk({req, " R8 no write"}, 32'(wr_cnt - w0), 0);
        end else begin
            chk({req, " write count"}, 32'(wr_cnt - w0), 1);
            chk({req, " R6 addr"}, 32'(cap_addr), 32'(cfg_dst_addr));
            chk({req, " R6 be"}, 32'(cap_be), (32'd1 << nb) - 1);
            chk({req, " R3 R6 data"}, cap_data, ed);
        end
    endtask

    task automatic t_reset();
        chk("R11 reset busy", 32'(busy), 0);
        chk("R11 reset done", 32'(done), 0);
        chk("R11 reset aborted", 32'(aborted), 0);
        chk("R2 reset rd_req", 32'(rd_req), 0);
    endtask

    task automatic t_reject();
        int r0 = rd_cnt;
        cfg_src_addr = 16'h10; cfg_src_size = 16'd4; cfg_pat_en = 1'b0;
        cfg_append_en = 1'b0; pulse_start(); repeat (3) @(negedge clk);
        chk("R1 append off stays idle", 32'(busy), 0);
        cfg_append_en = 1'b1; cfg_crc_en = 1'b0; pulse_start(); repeat (3) @(negedge clk);
        chk("R1 crc off stays idle", 32'(busy), 0);
        cfg_crc_en = 1'b1; cfg_chan = 3'd5; pulse_start(); repeat (3) @(negedge clk);
        chk("R1 channel mismatch stays idle", 32'(busy), 0);
        cfg_chan = 3'd0; cfg_src_size = 16'd0; pulse_start(); repeat (3) @(negedge clk);
        chk("R1 zero size stays idle", 32'(busy), 0);
        chk("R1 no reads issued", 32'(rd_cnt - r0), 0);
    endtask

    task automatic t_abort();
        int w0 = wr_cnt, d0 = done_cnt, r0 = rd_cnt;
        cfg_src_addr = 16'h30; cfg_src_size = 16'd8; cfg_dst_size = 16'd4; cfg_pat_en = 1'b0;
        pulse_start();
        repeat (14) @(negedge clk);
        abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
        wait_idle();
        chk("R9 aborted set", 32'(aborted), 1);
        chk("R9 no write", 32'(wr_cnt - w0), 0);
        chk("R9 no done", 32'(done_cnt - d0), 0);
        chk("R9 scan cut short", 32'((rd_cnt - r0) < 8), 1);
    endtask

    task automatic t_rderr();
        int w0 = wr_cnt, d0 = done_cnt, r0 = rd_cnt;
        err_en = 1'b1; err_addr = 16'h52;
        cfg_src_addr = 16'h50; cfg_src_size = 16'd6; cfg_pat_en = 1'b0;
        pulse_start();
        wait_idle();
        err_en = 1'b0;
        chk("R10 aborted set", 32'(aborted), 1);
        chk("R10 reads stop at error", 32'(rd_cnt - r0), 3);
        chk("R10 no write", 32'(wr_cnt - w0), 0);
        chk("R10 no done", 32'(done_cnt - d0), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_case("R2 R3 basic", 16, 5, 4, 15, 16'hA001, 16'hFFFF, 1'b0, 8'h00, 5);
        run_case("R7 8-bit crc", 32, 9, 4, 7, 16'h008C, 16'h0000, 1'b0, 8'h00, 9);
        run_case("R6 two bytes", 48, 3, 2, 15, 16'h8408, 16'h1234, 1'b0, 8'h00, 3);
        run_case("R6 one byte", 60, 4, 1, 15, 16'hA001, 16'hBEEF, 1'b0, 8'h00, 4);
        run_case("R4 large dst", 70, 6, 9, 11, 16'h0C99, 16'h0ABC, 1'b0, 8'h00, 6);
        run_case("R8 zero dst", 80, 2, 0, 15, 16'hA001, 16'hFFFF, 1'b0, 8'h00, 2);
        run_case("R5 pattern", 64, 10, 4, 15, 16'hA001, 16'hFFFF, 1'b1, mem[67], 4);
        run_case("R5 R4 pattern absent", 90, 3, 4, 15, 16'hA001, 16'h0000, 1'b1, mem[200], 3);
        t_reject();
        t_abort();
        run_case("R11 clears aborted", 100, 3, 4, 15, 16'hA001, 16'h5555, 1'b0, 8'h00, 3);
        t_rderr();
        run_case("R11 recover after error", 120, 2, 3, 15, 16'hA001, 16'hFFFF, 1'b0, 8'h00, 2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule